// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block sends and receives asynchronous serial characters. It does not generate a baud rate. An external generator supplies a one-cycle `tick` at sixteen times the bit rate, and every bit lasts sixteen ticks. A two-bit mode field picks the character format: eight data bits with no parity bit, seven data bits followed by a parity bit, or eight data bits followed by a parity bit. Separate controls choose one or two stop bits and odd or even parity. Further controls enable parity checking, framing-error detection and overrun detection.

The transmit side holds one character in a buffer. That character moves into the shifter as soon as the shifter is idle, so a second character can be queued while the first is on the line. The receive side has its own set of controls. It is switched on by a one-cycle set strobe. It checks each start bit at mid-bit and samples every following bit at its centre. It then presents the character in a holding register with a valid flag. Each error flag is sticky and has its own clear strobe. Reading the data never clears an error flag.

Top module: `frame_uart`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits least significant first, then an optional parity bit, then the stop bits, which are high. Mode codes: 0 = eight bits with no parity, 1 = seven bits plus parity, 2 = eight bits plus parity, 3 = the same as 0.
- R2: `twoStop` = 1 sends two stop bits and makes the receiver check two. When 0, one stop bit is used. Each bit lasts 16 ticks.
- R3: In modes 1 and 2, the parity bit is sent whether or not checking is enabled. It makes the number of ones over the data bits and the parity bit even when `parityOdd` = 0, and odd when `parityOdd` = 1.
- R4: `txEmpty` is high when the transmit buffer can take a character. A `txWrite` while `txEmpty` is low is ignored, and the buffered character is kept.
- R5: After reset the receiver is off and ignores all line activity. A pulse on `rxEnSet` turns it on.
- R6: A start bit is accepted only if the line is still low eight ticks after the falling edge was seen. A shorter low pulse produces no character.
- R7: A completed frame sets `rxValid` and presents the character on `rxData`. In mode 1, bit 7 of `rxData` reads 0. `rxRead` clears `rxValid`.
- R8: With `parityEn` = 1 in a parity mode, a received parity bit that does not match sets `parityErr`. With `parityEn` = 0, no parity error is flagged.
- R9: With `frameErrEn` = 1, a stop bit sampled low sets `frameErr`. The character is still delivered.
- R10: A frame that completes while `rxValid` is high and no read is made in that cycle is discarded, and the old character stays. If `overrunErrEn` = 1, this sets `overrunErr`.
- R11: Each error flag stays set until a pulse on its own clear input. Reading data or clearing a different flag leaves it set.
- R12: After reset: `txd` = 1, `txEmpty` = 1, `rxValid` = 0, and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, 16 per bit |
| mode | input | 2 | Character format code |
| twoStop | input | 1 | 1 = two stop bits |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| parityEn | input | 1 | Enable received parity check |
| frameErrEn | input | 1 | Enable framing error detection |
| overrunErrEn | input | 1 | Enable overrun detection |
| rxEnSet | input | 1 | Pulse that turns the receiver on |
| txWrite | input | 1 | Write strobe for the transmit buffer |
| txData | input | 8 | Character to send |
| txEmpty | output | 1 | Transmit buffer can accept a write |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rxRead | input | 1 | Pulse that consumes the received character |
| rxData | output | 8 | Received character |
| rxValid | output | 1 | A received character is waiting |
| clrFrameErr | input | 1 | Clear strobe for frameErr |
| clrParityErr | input | 1 | Clear strobe for parityErr |
| clrOverrunErr | input | 1 | Clear strobe for overrunErr |
| frameErr | output | 1 | Sticky framing error |
| parityErr | output | 1 | Sticky parity error |
| overrunErr | output | 1 | Sticky overrun error |

## Verification
A transmitter looped back to the receiver can never produce a bad stop bit, a bad parity bit or a runt start pulse. The bench therefore drives the receive line itself for those cases. It holds the stop bit low for only three quarters of a bit, so the mid-bit sample sees low, but the low that remains after the frame completes is too short to pass the start-bit check. It flips the parity bit in an arithmetically built frame. It also sends two frames back to back without a read. The loopback sweep covers every mode code, both stop settings and both parity senses. Each transmitted waveform is compared bit by bit with a frame computed in the bench.

// File: rtl/frame_uart_pkg.sv
package frame_uart_pkg;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned FRAME_W = CHAR_W + 4;
  localparam int unsigned IDX_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    MODE_8N   = 2'd0,
    MODE_7P   = 2'd1,
    MODE_8P   = 2'd2,
    MODE_RSVD = 2'd3
  } frameMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             txLoad;
    logic             txShift;
    logic             txActive;
    logic             rxStart;
    logic             rxSample;
    logic             rxIsStop;
    logic             rxCommit;
    logic [IDX_W-1:0] rxIdx;
  } strobe_t;

  function automatic logic [IDX_W-1:0] charBits(input logic [1:0] m);
    return (m == MODE_7P) ? IDX_W'(CHAR_W - 1) : IDX_W'(CHAR_W);
  endfunction

  function automatic logic withParity(input logic [1:0] m);
    return (m == MODE_7P) || (m == MODE_8P);
  endfunction
endpackage

// File: rtl/frame_uart_ctrl.sv
module frame_uart_ctrl
  import frame_uart_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       twoStop,
  input  logic       rxEnSet,
  input  logic       txFull,
  input  logic       rxLine,
  output strobe_t    stb
);
  localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_e;

  logic             txActive;
  logic [CNT_W-1:0] txTick;
  logic [IDX_W-1:0] txLeft;
  logic             rxOn;
  rxState_e         rxState;
  logic [CNT_W-1:0] rxTick;
  logic [IDX_W-1:0] rxIdx;
  logic [IDX_W-1:0] stopIdx, bodyLen, frameLen, lastIdx;

  // frame geometry from the live configuration
  always_comb begin
    stopIdx  = charBits(mode) + IDX_W'(withParity(mode));
    bodyLen  = stopIdx + (twoStop ? IDX_W'(2) : IDX_W'(1));
    frameLen = bodyLen + IDX_W'(1);
    lastIdx  = bodyLen - IDX_W'(1);
  end

  always_comb begin
    stb          = '0;
    stb.txLoad   = !txActive && txFull;
    stb.txShift  = txActive && tick && (txTick == LAST_TICK);
    stb.txActive = txActive;
    stb.rxStart  = (rxState == RX_START) && tick && (rxTick == MID_TICK) && !rxLine;
    stb.rxSample = (rxState == RX_BITS) && tick && (rxTick == LAST_TICK);
    stb.rxIsStop = (rxIdx >= stopIdx);
    stb.rxCommit = (rxState == RX_BITS) && tick && (rxTick == LAST_TICK) && (rxIdx == lastIdx);
    stb.rxIdx    = rxIdx;
  end

  // transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txTick   <= '0;
      txLeft   <= '0;
    end else if (!txActive) begin
      if (txFull) begin
        txActive <= 1'b1;
        txTick   <= '0;
        txLeft   <= frameLen;
      end
    end else if (tick) begin
      if (txTick == LAST_TICK) begin
        txTick <= '0;
        txLeft <= txLeft - IDX_W'(1);
        if (txLeft == IDX_W'(1)) txActive <= 1'b0;
      end else begin
        txTick <= txTick + CNT_W'(1);
      end
    end
  end

  // receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOn    <= 1'b0;
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxIdx   <= '0;
    end else begin
      if (rxEnSet) rxOn <= 1'b1;
      case (rxState)
        RX_IDLE: begin
          if (rxOn && tick && !rxLine) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxTick == MID_TICK) begin
              rxTick  <= '0;
              rxIdx   <= '0;
              rxState <= rxLine ? RX_IDLE : RX_BITS;
            end else begin
              rxTick <= rxTick + CNT_W'(1);
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (rxTick == LAST_TICK) begin
              rxTick <= '0;
              rxIdx  <= rxIdx + IDX_W'(1);
              if (rxIdx == lastIdx) rxState <= RX_IDLE;
            end else begin
              rxTick <= rxTick + CNT_W'(1);
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  AST_RX_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !rxOn |-> rxState == RX_IDLE); // R5
  AST_TX_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> txLeft != '0); // R2
endmodule

// File: rtl/frame_uart_dp.sv
module frame_uart_dp
  import frame_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        mode,
  input  logic              parityOdd,
  input  logic              parityEn,
  input  logic              frameErrEn,
  input  logic              overrunErrEn,
  input  logic              txWrite,
  input  logic [CHAR_W-1:0] txData,
  output logic              txd,
  output logic              txFull,
  input  logic              rxd,
  output logic              rxLine,
  input  logic              rxRead,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxValid,
  input  logic              clrFrameErr,
  input  logic              clrParityErr,
  input  logic              clrOverrunErr,
  output logic              frameErr,
  output logic              parityErr,
  output logic              overrunErr
);
  logic [CHAR_W-1:0]  txBuf;
  logic [FRAME_W-1:0] txShreg;
  logic [1:0]         rxSync;
  logic [FRAME_W-1:0] rxBits;
  logic               stopBad;
  logic [CHAR_W-1:0]  rxChar;
  logic               rxParBit, badStop, parMiss, overrun;

  function automatic logic [FRAME_W-1:0] packFrame(input logic [1:0] m, input logic odd,
                                                    input logic [CHAR_W-1:0] d);
    logic [FRAME_W-1:0] f;
    logic [CHAR_W-1:0]  body;
    body = (m == MODE_7P) ? {1'b0, d[CHAR_W-2:0]} : d;
    f = '1;
    f[0] = 1'b0;
    f[CHAR_W:1] = body;
    if (withParity(m)) f[int'(charBits(m)) + 1] = odd ^ (^body);
    return f;
  endfunction

  // transmit buffer and shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txFull  <= 1'b0;
      txShreg <= '1;
    end else begin
      if (stb.txLoad) begin
        txFull  <= 1'b0;
        txShreg <= packFrame(mode, parityOdd, txBuf);
      end else begin
        if (txWrite && !txFull) begin
          txBuf  <= txData;
          txFull <= 1'b1;
        end
        if (stb.txShift) txShreg <= {1'b1, txShreg[FRAME_W-1:1]};
      end
    end
  end
  assign txd = txShreg[0];

  // receive capture
  assign rxLine = rxSync[1];

  always_comb begin
    rxChar   = (mode == MODE_7P) ? {1'b0, rxBits[CHAR_W-2:0]} : rxBits[CHAR_W-1:0];
    rxParBit = rxBits[int'(charBits(mode))];
    badStop  = stopBad | !rxLine;
    parMiss  = withParity(mode) && (rxParBit != (parityOdd ^ (^rxChar)));
    overrun  = rxValid && !rxRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync     <= 2'b11;
      rxBits     <= '0;
      stopBad    <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (stb.rxStart) stopBad <= 1'b0;
      if (stb.rxSample) begin
        if (!stb.rxIsStop) rxBits[stb.rxIdx] <= rxLine;
        else if (!rxLine)  stopBad <= 1'b1;
      end
      if (stb.rxCommit && !overrun) begin
        rxData  <= rxChar;
        rxValid <= 1'b1;
      end else if (rxRead) begin
        rxValid <= 1'b0;
      end
      frameErr   <= (stb.rxCommit && frameErrEn && badStop) | (frameErr & !clrFrameErr);
      parityErr  <= (stb.rxCommit && parityEn && parMiss) | (parityErr & !clrParityErr);
      overrunErr <= (stb.rxCommit && overrunErrEn && overrun) | (overrunErr & !clrOverrunErr);
    end
  end

  AST_TXD_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.txActive |-> txd); // R1
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && txFull && !stb.txLoad) |=> $stable(txBuf)); // R4
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxCommit && rxValid && !rxRead) |=> $stable(rxData)); // R10
  AST_FRAME_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clrFrameErr) |=> frameErr); // R11
  AST_SEVEN_BIT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxCommit && !overrun && mode == MODE_7P) |=> !rxData[CHAR_W-1]); // R7
endmodule

// File: rtl/frame_uart.sv
module frame_uart
  import frame_uart_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       twoStop,
  input  logic       parityOdd,
  input  logic       parityEn,
  input  logic       frameErrEn,
  input  logic       overrunErrEn,
  input  logic       rxEnSet,
  input  logic       txWrite,
  input  logic [7:0] txData,
  output logic       txEmpty,
  output logic       txd,
  input  logic       rxd,
  input  logic       rxRead,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       clrFrameErr,
  input  logic       clrParityErr,
  input  logic       clrOverrunErr,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrunErr
);
  strobe_t stb;
  logic    txFull;
  logic    rxLine;

  frame_uart_ctrl #(.OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .mode(mode), .twoStop(twoStop),
    .rxEnSet(rxEnSet), .txFull(txFull), .rxLine(rxLine), .stb(stb)
  );

  frame_uart_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode), .parityOdd(parityOdd),
    .parityEn(parityEn), .frameErrEn(frameErrEn), .overrunErrEn(overrunErrEn),
    .txWrite(txWrite), .txData(txData), .txd(txd), .txFull(txFull),
    .rxd(rxd), .rxLine(rxLine), .rxRead(rxRead), .rxData(rxData), .rxValid(rxValid),
    .clrFrameErr(clrFrameErr), .clrParityErr(clrParityErr), .clrOverrunErr(clrOverrunErr),
    .frameErr(frameErr), .parityErr(parityErr), .overrunErr(overrunErr)
  );

  assign txEmpty = !txFull;
endmodule

// File: tb/test_frame_uart.sv
module test_frame_uart;
  localparam int BIT_CLK = 64; // 16 ticks of 4 clocks

  logic clk = 0, rstN = 0, tick = 0;
  logic [1:0] mode = 0;
  logic twoStop = 0, parityOdd = 0, parityEn = 0, frameErrEn = 0, overrunErrEn = 0;
  logic rxEnSet = 0, txWrite = 0, rxRead = 0;
  logic [7:0] txData = 0;
  logic clrFrameErr = 0, clrParityErr = 0, clrOverrunErr = 0;
  logic txEmpty, txd, rxValid, frameErr, parityErr, overrunErr;
  logic [7:0] rxData;
  logic loopBack = 0, benchRxd = 1, rxd;
  int checks = 0, errors = 0, tickDiv = 0;

  assign rxd = loopBack ? txd : benchRxd;

  frame_uart i_frame_uart (
    .clk(clk), .rstN(rstN), .tick(tick), .mode(mode), .twoStop(twoStop),
    .parityOdd(parityOdd), .parityEn(parityEn), .frameErrEn(frameErrEn),
    .overrunErrEn(overrunErrEn), .rxEnSet(rxEnSet), .txWrite(txWrite), .txData(txData),
    .txEmpty(txEmpty), .txd(txd), .rxd(rxd), .rxRead(rxRead), .rxData(rxData),
    .rxValid(rxValid), .clrFrameErr(clrFrameErr), .clrParityErr(clrParityErr),
    .clrOverrunErr(clrOverrunErr), .frameErr(frameErr), .parityErr(parityErr),
    .overrunErr(overrunErr)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tick    <= (tickDiv == 3);
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseRead;     rxRead = 1;        clocks(1); rxRead = 0;        endtask
  task automatic pulseClrFrame; clrFrameErr = 1;   clocks(1); clrFrameErr = 0;   endtask
  task automatic pulseClrPar;   clrParityErr = 1;  clocks(1); clrParityErr = 0;  endtask
  task automatic pulseClrOvr;   clrOverrunErr = 1; clocks(1); clrOverrunErr = 0; endtask

  task automatic sendTx(input int d);
    txData = d[7:0]; txWrite = 1; clocks(1); txWrite = 0;
  endtask

  function automatic int expFrame(input int m, input bit two, input bit odd, input int d,
                                  output int len);
    int nd, body, f, pos;
    bit par;
    nd   = (m == 1) ? 7 : 8;
    par  = (m == 1) || (m == 2);
    body = d & ((1 << nd) - 1);
    f    = body << 1;
    pos  = nd + 1;
    if (par) begin
      f = f | (int'(odd ^ (^body)) << pos);
      pos++;
    end
    f = f | (1 << pos); pos++;
    if (two) begin f = f | (1 << pos); pos++; end
    len = pos;
    return f;
  endfunction

  task automatic captureTx(input int len, output int got);
    int w;
    w = 0;
    while (txd !== 1'b0 && w < 2000) begin clocks(1); w++; end
    clocks(BIT_CLK / 2);
    got = 0;
    for (int i = 0; i < len; i++) begin
      got = got | (int'(txd) << i);
      if (i < len - 1) clocks(BIT_CLK);
    end
  endtask

  task automatic driveRx(input int frame, input int len, input bit shortStop);
    loopBack = 0;
    for (int i = 0; i < len; i++) begin
      if (shortStop && i == len - 1) begin
        benchRxd = 0; clocks(48); benchRxd = 1; clocks(16);
      end else begin
        benchRxd = frame[i]; clocks(BIT_CLK);
      end
    end
    benchRxd = 1;
    clocks(BIT_CLK);
  endtask

  initial begin
    int f, len, got, mask;
    int pats[5] = '{'h00, 'hFF, 'hA5, 'h5A, 'h81};
    clocks(3);
    rstN = 1;
    clocks(2);
    // R12 reset state
    check("R12 txd", txd, 1);
    check("R12 txEmpty", txEmpty, 1);
    check("R12 rxValid", rxValid, 0);
    check("R12 flags", {frameErr, parityErr, overrunErr}, 0);

    // R5 receiver off until set
    f = expFrame(0, 0, 0, 'h5A, len);
    driveRx(f, len, 0);
    check("R5 receiver off ignores frame", rxValid, 0);
    rxEnSet = 1; clocks(1); rxEnSet = 0;
    driveRx(f, len, 0);
    check("R5 receiver on valid", rxValid, 1);
    check("R5 receiver on data", rxData, 'h5A);
    pulseRead;
    check("R7 read clears valid", rxValid, 0);

    // loopback sweep over every format
    parityEn = 1; frameErrEn = 1; overrunErrEn = 1;
    for (int m = 0; m < 4; m++)
      for (int two = 0; two < 2; two++)
        for (int odd = 0; odd < 2; odd++)
          for (int k = 0; k < 5; k++) begin
            mode = m[1:0]; twoStop = two[0]; parityOdd = odd[0]; loopBack = 1;
            f = expFrame(m, two[0], odd[0], pats[k], len);
            mask = (m == 1) ? 'h7F : 'hFF;
            sendTx(pats[k]);
            captureTx(len, got);
            clocks(BIT_CLK);
            check($sformatf("R1 R2 R3 tx frame m%0d s%0d o%0d", m, two, odd), got, f);
            check("R7 rx valid loopback", rxValid, 1);
            check($sformatf("R7 rx data m%0d", m), rxData, pats[k] & mask);
            check("R8 R9 R10 no error on clean frame", {frameErr, parityErr, overrunErr}, 0);
            pulseRead;
          end

    // R6 runt start pulse
    mode = 0; twoStop = 0; parityOdd = 0; loopBack = 0;
    benchRxd = 0; clocks(8); benchRxd = 1; clocks(800);
    check("R6 runt start ignored", rxValid, 0);

    // R9 framing error, R11 stickiness
    f = expFrame(0, 0, 0, 'h55, len);
    driveRx(f, len, 1);
    check("R9 frame error set", frameErr, 1);
    check("R9 data still delivered", rxData, 'h55);
    pulseRead;
    check("R11 read keeps frameErr", frameErr, 1);
    pulseClrPar;
    check("R11 other clear keeps frameErr", frameErr, 1);
    pulseClrFrame;
    check("R11 own clear drops frameErr", frameErr, 0);
    frameErrEn = 0;
    driveRx(f, len, 1);
    check("R9 disabled no frame error", frameErr, 0);
    pulseRead;
    frameErrEn = 1;

    // R8 parity error
    mode = 1;
    f = expFrame(1, 0, 0, 'h35, len) ^ (1 << 8);
    driveRx(f, len, 0);
    check("R8 parity error set", parityErr, 1);
    check("R8 data delivered", rxData, 'h35);
    pulseRead;
    pulseClrPar;
    check("R11 parity clear", parityErr, 0);
    parityEn = 0;
    driveRx(f, len, 0);
    check("R8 disabled no parity error", parityErr, 0);
    pulseRead;
    parityEn = 1;

    // R10 overrun
    mode = 0;
    f = expFrame(0, 0, 0, 'h11, len); driveRx(f, len, 0);
    f = expFrame(0, 0, 0, 'h22, len); driveRx(f, len, 0);
    check("R10 overrun flag", overrunErr, 1);
    check("R10 old data kept", rxData, 'h11);
    pulseRead;
    check("R10 second frame dropped", rxValid, 0);
    pulseClrOvr;
    check("R11 overrun clear", overrunErr, 0);
    overrunErrEn = 0;
    f = expFrame(0, 0, 0, 'h33, len); driveRx(f, len, 0);
    f = expFrame(0, 0, 0, 'h44, len); driveRx(f, len, 0);
    check("R10 disabled no overrun flag", overrunErr, 0);
    check("R10 disabled old data kept", rxData, 'h33);
    pulseRead;

    // R4 transmit buffer
    loopBack = 1;
    sendTx('h12);
    clocks(3);
    check("R4 buffer empty after move to shifter", txEmpty, 1);
    sendTx('h34);
    check("R4 buffer full", txEmpty, 0);
    sendTx('h56);
    clocks(10 * BIT_CLK);
    check("R4 first char", rxData, 'h12);
    pulseRead;
    clocks(10 * BIT_CLK);
    check("R4 queued char", rxData, 'h34);
    check("R4 queued char valid", rxValid, 1);
    pulseRead;
    clocks(11 * BIT_CLK);
    check("R4 write while full ignored", rxValid, 0);
    check("R4 empty at end", txEmpty, 1);
    check("R1 line idles high", txd, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule